// File: doc/BRIEF.md
# Timing-Recovery PI Loop Filter

This block is the loop filter of a symbol timing-recovery phase-locked loop. Each time the phase detector presents a signed phase-error sample with its valid strobe, the filter can flip the sample's sign. It then scales the sample by a selectable detector gain and forms a frequency-control word. That word is the sum of a proportional term and a saturating integrator. One pulse of `freq_valid` follows each sample, one clock later. The oscillator that consumes the word, the detector that makes the error and the rate clocking all sit outside the block.

An 8-bit mode register, written and read over a simple bus port, configures everything. One 2-bit loop-gain code sets the proportional and integral gains together, as power-of-two shifts with unequal ratios. A freeze bit holds the loop at its current frequency: the proportional term is zeroed and the integrator stops. A two-state machine tracks freeze. In state LOOP_TRACK the filter updates normally. A write that sets the freeze bit takes the transition TRACK→HOLD into state LOOP_HOLD, where the integrator is held. A write that clears the bit takes HOLD→TRACK. Any other write leaves the state as it is. A 2-bit clock-range field is only stored and exported.

Top module: `pi_timing_filter`

## Requirements
- R1: After reset the mode register reads 0x00, `rate_sel` is 0, `freq_word` is 0, `freq_valid` is low and the integrator is zero.
- R2: A write stores all 8 bits and a read returns exactly the bits written, reserved codes included. The layout is: bits [7:6] clock range, bit [5] negate, bits [4:3] detector gain, bit [2] freeze, bits [1:0] loop gain.
- R3: `rate_sel` always equals mode bits [7:6].
- R4: Detector gain code 00 multiplies the error by 1, 01 by 2 and 10 by 4. Reserved code 11 multiplies by 1.
- R5: When the negate bit is 1, the error's sign is inverted before gain scaling.
- R6: Loop gain code 0, 1, 2 or 3 shifts the scaled error left by 0, 2, 4 or 6 for the proportional term and by 0, 5, 8 or 12 for the integral increment.
- R7: In LOOP_TRACK each sample adds its integral increment to the 32-bit integrator, saturating at the signed 32-bit limits.
- R8: `freq_word` is the updated integrator plus the proportional term, saturated to the signed 24-bit output range. It is registered so that `freq_valid` pulses for exactly one cycle after each sample cycle. Between samples `freq_word` holds its value.
- R9: In LOOP_HOLD (freeze bit 1) a sample leaves the integrator unchanged, and `freq_word` becomes the saturated held integrator with no proportional contribution.
- R10: Clearing the freeze bit returns the filter to LOOP_TRACK, and tracking resumes from the held integrator value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 8 | Mode register write data |
| cfg_rdata | output | 8 | Mode register read data |
| rate_sel | output | 2 | Exported clock-range field |
| err_valid | input | 1 | Phase-error sample strobe |
| err_in | input | ERR_W (12) | Signed phase-error sample |
| freq_valid | output | 1 | Frequency word update strobe |
| freq_word | output | OUT_W (24) | Signed frequency-control word |

## Verification
The assertions assume that `err_valid` and `cfg_we` are never unknown after reset, and that the freeze state starts in agreement with the register: both are cleared by the same reset. They also take for granted that a configuration write and a sample may share a cycle, in which case the sample uses the old mode. The stimulus avoids that overlap, so the scoreboard's mode copy always matches the mode the design applied. Every sample is driven on a falling edge and held for exactly one cycle, so each sample produces one expected item.

// File: rtl/pi_loop_pkg.sv
package pi_loop_pkg;

    typedef enum logic [0:0] {
        LOOP_TRACK = 1'b0,
        LOOP_HOLD  = 1'b1
    } loop_state_t;

    typedef struct packed {
        logic [1:0] rate;
        logic       negate;
        logic [1:0] pd_gain;
        logic       freeze;
        logic [1:0] loop_gain;
    } mode_t;

    function automatic logic [1:0] pd_shift(input logic [1:0] code);
        logic [1:0] sh;
        unique case (code)
            2'b01:   sh = 2'd1;
            2'b10:   sh = 2'd2;
            default: sh = 2'd0;
        endcase
        return sh;
    endfunction

    function automatic logic [3:0] prop_shift(input logic [1:0] code);
        logic [3:0] sh;
        unique case (code)
            2'b00:   sh = 4'd0;
            2'b01:   sh = 4'd2;
            2'b10:   sh = 4'd4;
            default: sh = 4'd6;
        endcase
        return sh;
    endfunction

    function automatic logic [3:0] integ_shift(input logic [1:0] code);
        logic [3:0] sh;
        unique case (code)
            2'b00:   sh = 4'd0;
            2'b01:   sh = 4'd5;
            2'b10:   sh = 4'd8;
            default: sh = 4'd12;
        endcase
        return sh;
    endfunction

endpackage

// File: rtl/pi_mode_reg.sv
module pi_mode_reg
    import pi_loop_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    output mode_t      mode_q,
    output logic [7:0] rdata
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (we) begin
            mode_q <= mode_t'(wdata);
        end
    end

    assign rdata = mode_q;

endmodule

// File: rtl/pi_err_scaler.sv
module pi_err_scaler
    import pi_loop_pkg::*;
#(
    parameter int ERR_W = 12,
    localparam int SC_W = ERR_W + 3
) (
    input  logic signed [ERR_W-1:0] err,
    input  logic                    negate,
    input  logic [1:0]              pd_code,
    output logic signed [SC_W-1:0]  scaled
);

    logic signed [SC_W-1:0] ext;
    logic signed [SC_W-1:0] signed_err;

    always_comb begin
        ext        = {{(SC_W-ERR_W){err[ERR_W-1]}}, err};
        signed_err = negate ? -ext : ext;
        scaled     = signed_err <<< pd_shift(pd_code);
    end

endmodule

// File: rtl/pi_core.sv
module pi_core
    import pi_loop_pkg::*;
#(
    parameter int SC_W  = 15,
    parameter int ACC_W = 32,
    parameter int OUT_W = 24,
    localparam int WIDE = ACC_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valid,
    input  logic signed [SC_W-1:0]  scaled,
    input  logic [1:0]              lg_code,
    input  logic                    hold_set,
    input  logic                    hold_clr,
    output loop_state_t             state_q,
    output logic signed [ACC_W-1:0] acc_q,
    output logic signed [OUT_W-1:0] out_q,
    output logic                    out_valid_q
);

    localparam logic signed [WIDE-1:0] ACC_MAX = {{(WIDE-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
    localparam logic signed [WIDE-1:0] ACC_MIN = ~ACC_MAX;
    localparam logic signed [WIDE-1:0] OUT_MAX = {{(WIDE-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [WIDE-1:0] OUT_MIN = ~OUT_MAX;

    loop_state_t             state_d;
    logic signed [WIDE-1:0]  sc_w;
    logic signed [WIDE-1:0]  prop_w;
    logic signed [WIDE-1:0]  integ_w;
    logic signed [WIDE-1:0]  acc_w;
    logic signed [WIDE-1:0]  acc_sum;
    logic signed [WIDE-1:0]  acc_sat;
    logic signed [ACC_W-1:0] acc_d;
    logic signed [WIDE-1:0]  acc_d_w;
    logic signed [WIDE-1:0]  out_sum;
    logic signed [WIDE-1:0]  out_sat;
    logic                    holding;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LOOP_TRACK;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LOOP_TRACK: if (hold_set) state_d = LOOP_HOLD;
            LOOP_HOLD:  if (hold_clr) state_d = LOOP_TRACK;
            default:    state_d = LOOP_TRACK;
        endcase
    end

    // datapath
    always_comb begin
        holding = (state_q == LOOP_HOLD);
        sc_w    = {{(WIDE-SC_W){scaled[SC_W-1]}}, scaled};
        prop_w  = sc_w <<< prop_shift(lg_code);
        integ_w = sc_w <<< integ_shift(lg_code);
        acc_w   = {{(WIDE-ACC_W){acc_q[ACC_W-1]}}, acc_q};
        acc_sum = acc_w + integ_w;
        if (acc_sum > ACC_MAX) begin
            acc_sat = ACC_MAX;
        end else if (acc_sum < ACC_MIN) begin
            acc_sat = ACC_MIN;
        end else begin
            acc_sat = acc_sum;
        end
        acc_d   = holding ? acc_q : acc_sat[ACC_W-1:0];
        acc_d_w = {{(WIDE-ACC_W){acc_d[ACC_W-1]}}, acc_d};
        out_sum = acc_d_w + (holding ? '0 : prop_w);
        if (out_sum > OUT_MAX) begin
            out_sat = OUT_MAX;
        end else if (out_sum < OUT_MIN) begin
            out_sat = OUT_MIN;
        end else begin
            out_sat = out_sum;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q       <= '0;
            out_q       <= '0;
            out_valid_q <= 1'b0;
        end else begin
            out_valid_q <= valid;
            if (valid) begin
                acc_q <= acc_d;
                out_q <= out_sat[OUT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/pi_timing_filter.sv
module pi_timing_filter
    import pi_loop_pkg::*;
#(
    parameter int ERR_W = 12,
    parameter int ACC_W = 32,
    parameter int OUT_W = 24,
    localparam int SC_W = ERR_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    output logic [1:0]       rate_sel,
    input  logic             err_valid,
    input  logic [ERR_W-1:0] err_in,
    output logic             freq_valid,
    output logic [OUT_W-1:0] freq_word
);

    mode_t                   mode_q;
    loop_state_t             state_w;
    logic signed [ACC_W-1:0] acc_w;
    logic signed [OUT_W-1:0] out_w;
    logic signed [SC_W-1:0]  scaled_w;
    logic                    hold_set;
    logic                    hold_clr;
    logic                    hold_bit;

    pi_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .mode_q (mode_q),
        .rdata  (cfg_rdata)
    );

    pi_err_scaler #(.ERR_W(ERR_W)) u_scale (
        .err     (err_in),
        .negate  (mode_q.negate),
        .pd_code (mode_q.pd_gain),
        .scaled  (scaled_w)
    );

    assign hold_bit = mode_q.freeze;
    assign hold_set = cfg_we &  cfg_wdata[2] & ~hold_bit;
    assign hold_clr = cfg_we & ~cfg_wdata[2] &  hold_bit;

    pi_core #(.SC_W(SC_W), .ACC_W(ACC_W), .OUT_W(OUT_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid       (err_valid),
        .scaled      (scaled_w),
        .lg_code     (mode_q.loop_gain),
        .hold_set    (hold_set),
        .hold_clr    (hold_clr),
        .state_q     (state_w),
        .acc_q       (acc_w),
        .out_q       (out_w),
        .out_valid_q (freq_valid)
    );

    assign rate_sel  = mode_q.rate;
    assign freq_word = out_w;

endmodule

// File: rtl/pi_timing_filter_chk.sv
module pi_timing_filter_chk
    import pi_loop_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int OUT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [7:0]       cfg_wdata,
    input logic [7:0]       cfg_rdata,
    input logic [1:0]       rate_sel,
    input logic             err_valid,
    input logic             freq_valid,
    input logic [OUT_W-1:0] freq_word,
    input logic [ACC_W-1:0] acc,
    input logic             hold_bit,
    input loop_state_t      state
);

    AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_rdata == $past(cfg_wdata)); // R2

    AST_RATE_EXPORT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> rate_sel == $past(cfg_wdata[7:6])); // R3

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |=> freq_valid); // R8

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid |=> !freq_valid); // R8

    AST_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid |=> $stable(freq_word)); // R8

    AST_STATE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LOOP_HOLD) == hold_bit); // R9

    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && state == LOOP_HOLD) |=> $stable(acc)); // R9

    AST_ACC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid |=> $stable(acc)); // R7

endmodule

bind pi_timing_filter pi_timing_filter_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .rate_sel   (rate_sel),
    .err_valid  (err_valid),
    .freq_valid (freq_valid),
    .freq_word  (freq_word),
    .acc        (acc_w),
    .hold_bit   (hold_bit),
    .state      (state_w)
);

// File: tb/tb_pi_timing_filter.sv
module tb_pi_timing_filter;

    localparam int ERR_W = 12;
    localparam int ACC_W = 32;
    localparam int OUT_W = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [7:0]       cfg_wdata = '0;
    logic [7:0]       cfg_rdata;
    logic [1:0]       rate_sel;
    logic             err_valid = 1'b0;
    logic [ERR_W-1:0] err_in = '0;
    logic             freq_valid;
    logic [OUT_W-1:0] freq_word;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    longint m_acc = 0;
    logic [7:0] m_mode = '0;

    typedef struct {
        longint value;
        string  tag;
    } exp_t;
    exp_t sb[$];

    pi_timing_filter #(.ERR_W(ERR_W), .ACC_W(ACC_W), .OUT_W(OUT_W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .rate_sel   (rate_sel),
        .err_valid  (err_valid),
        .err_in     (err_in),
        .freq_valid (freq_valid),
        .freq_word  (freq_word)
    );

    always #4 clk = ~clk;

    task automatic check(input longint got, input longint exp, input string tag);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    function automatic longint sat(input longint v, input int w);
        longint hi;
        longint lo;
        hi = (longint'(1) <<< (w - 1)) - 1;
        lo = -(longint'(1) <<< (w - 1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    // reference model from the requirements
    function automatic longint model(input int err);
        longint e;
        int     psh;
        int     ish;
        e = err;
        if (m_mode[5]) e = -e;                       // R5
        if (m_mode[4:3] == 2'b01) e = e * 2;         // R4
        else if (m_mode[4:3] == 2'b10) e = e * 4;
        psh = 2 * int'(m_mode[1:0]);                 // R6
        case (m_mode[1:0])
            2'b00:   ish = 0;
            2'b01:   ish = 5;
            2'b10:   ish = 8;
            default: ish = 12;
        endcase
        if (m_mode[2]) begin                         // R9
            return sat(m_acc, OUT_W);
        end
        m_acc = sat(m_acc + (e <<< ish), ACC_W);     // R7
        return sat(m_acc + (e <<< psh), OUT_W);      // R8
    endfunction

    // driver: called at a falling edge, returns at the next one
    task automatic send(input int err, input string tag);
        exp_t it;
        it.value = model(err);
        it.tag   = tag;
        sb.push_back(it);
        err_valid = 1'b1;
        err_in    = ERR_W'(err);
        @(negedge clk);
        err_valid = 1'b0;
    endtask

    task automatic write_mode(input logic [7:0] v);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        m_mode = v;
        check(longint'(cfg_rdata), longint'(v), "R2 readback");
        check(longint'(rate_sel), longint'(v[7:6]), "R3 rate_sel");
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_acc  = 0;
        m_mode = '0;
        @(negedge clk);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && freq_valid) begin
                if (sb.size() == 0) begin
                    check(1, 0, "R8 unexpected freq_valid");
                end else begin
                    exp_t it;
                    it = sb.pop_front();
                    check(longint'($signed(freq_word)), it.value, it.tag);
                end
            end
        end
    end

    // watchdog
    initial begin
        #(8 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [OUT_W-1:0] held;
        do_reset();
        // R1 reset state
        check(longint'(cfg_rdata), 0, "R1 mode after reset");
        check(longint'(rate_sel), 0, "R1 rate after reset");
        check(longint'(freq_word), 0, "R1 word after reset");
        check(longint'(freq_valid), 0, "R1 valid after reset");

        // R2 / R3 register fields incl. reserved codes
        write_mode(8'hFF);
        write_mode(8'hC0);
        write_mode(8'h5A);
        write_mode(8'h80);
        do_reset();

        // R7 unity gains
        write_mode(8'h00);
        send(5, "R7 unity +5");
        send(-3, "R7 unity -3");
        send(100, "R7 unity +100");
        repeat (2) @(negedge clk);

        // R4 detector gains including reserved
        do_reset();
        write_mode(8'h08);
        send(7, "R4 pd x2");
        write_mode(8'h10);
        send(-9, "R4 pd x4");
        write_mode(8'h18);
        send(11, "R4 pd reserved x1");

        // R5 negate
        do_reset();
        write_mode(8'h20);
        send(40, "R5 negate +40");
        send(-25, "R5 negate -25");
        write_mode(8'h30);
        send(3, "R5 negate with x4");

        // R6 loop gains
        do_reset();
        write_mode(8'h01);
        send(3, "R6 gain code 1");
        write_mode(8'h02);
        send(-2, "R6 gain code 2");
        write_mode(8'h03);
        send(1, "R6 gain code 3");
        send(-1, "R6 gain code 3 neg");

        // R7 / R8 saturation positive then negative
        do_reset();
        write_mode(8'h13);
        for (int i = 0; i < 70; i++) send(2047, "R7 positive saturation");
        check(longint'($signed(freq_word)), (longint'(1) <<< (OUT_W-1)) - 1, "R8 positive clamp");
        for (int i = 0; i < 140; i++) send(-2048, "R7 negative saturation");
        check(longint'($signed(freq_word)), -(longint'(1) <<< (OUT_W-1)), "R8 negative clamp");

        // R9 / R10 freeze
        do_reset();
        write_mode(8'h01);
        send(10, "R9 prime");
        send(20, "R9 prime");
        write_mode(8'h05);
        send(1000, "R9 frozen sample");
        send(-700, "R9 frozen sample 2");
        held = freq_word;
        repeat (3) @(negedge clk);
        check(longint'(freq_word), longint'(held), "R8 word holds between samples");
        check(longint'(freq_valid), 0, "R8 valid low when idle");
        write_mode(8'h07);
        send(50, "R9 frozen with other gain");
        write_mode(8'h01);
        send(4, "R10 resume tracking");
        send(-6, "R10 resume tracking 2");
        @(negedge clk);
        check(longint'(sb.size()), 0, "R8 every sample answered");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule